// File: doc/BRIEF.md
# Stop-First Sequenced Serial Byte Transmitter

This block sends one byte per request over a single asynchronous serial line: a low start bit, eight data bits least significant first, then a high stop bit. Bit timing comes from a one-cycle baud tick enable, for example 9600 pulses per second derived from the system clock. A caller presents a byte on `din`, pulses `send` while `busy` is low, and keeps `din` steady until the frame has begun. After that the byte is held inside the block and `din` may change.

The sequencer is a ten-state counter. Its resting state is the stop state, so idle and stop are the same state. The states are ST_STOP (0), ST_START (1), and ST_D0 to ST_D7 (2 to 9), where ST_Dn carries data bit n. There are four transitions. ST_STOP holds while nothing is pending. ST_STOP goes to ST_START on a tick when a request is pending. Each of ST_START through ST_D6 moves to the next state on a tick. ST_D7 returns to ST_STOP on a tick. The tick that leaves ST_STOP also latches the byte. There is no shift register. A selector, indexed by the next state, picks the start level, one latched data bit, or the stop level. That level goes into a registered line driver that changes only on ticks.

Top module: `stopfirst_serial_tx`

## Requirements
- R1: While reset is asserted and directly after it, `txd` is 1 (idle/stop level), `busy` is 0 and the sequencer is in ST_STOP.
- R2: While no request is pending, the sequencer stays in ST_STOP and `txd` stays 1 across any number of ticks.
- R3: A frame is exactly: start bit 0 (state 1), then data bits 0..7 in that order (states 2..9, least significant first), then a stop bit 1 (state 0). `txd` is 0 whenever the state is ST_START and 1 whenever it is ST_STOP.
- R4: The byte on `din` is captured at the tick that moves ST_STOP to ST_START. Changes to `din` after that tick do not affect the frame in flight.
- R5: The state and `txd` change only on a cycle where `bit_tick` is 1. Every bit, the start bit included, lasts one full tick period, whatever the phase of `send` relative to the ticks.
- R6: A `send` pulse while `busy` is 0 is accepted. `busy` is 1 from the next cycle until the sequencer is back in ST_STOP with nothing pending.
- R7: A `send` pulse while `busy` is 1 is ignored: no extra frame follows, and the line stays at 1 afterwards.
- R8: After ST_D7 the sequencer always returns to ST_STOP for at least one full tick period, so consecutive frame starts are at least ten tick periods apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle baud tick enable |
| send | input | 1 | Transmit request pulse |
| din | input | 8 | Parallel byte to transmit |
| busy | output | 1 | Request pending or frame in progress |
| txd | output | 1 | Serial line, 1 = idle/stop level |

## Verification
On every cycle, the assertions check four things: state and line changes happen only on ticks, the line level matches ST_START and ST_STOP, ST_D7 always exits to a stop state driving 1, and a request made while busy leaves the pending flag untouched. Only the bench's scenarios can show the rest. These are the bit order of whole frames for several byte patterns, the full length of the start bit when requests arrive at different phases of the tick, immunity to `din` changes and to extra requests during a frame, and the spacing of back-to-back frames.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int DATA_W = 8;
    localparam int ST_W   = $clog2(DATA_W + 2);

    typedef enum logic [ST_W-1:0] {
        ST_STOP  = 4'd0,
        ST_START = 4'd1,
        ST_D0    = 4'd2,
        ST_D1    = 4'd3,
        ST_D2    = 4'd4,
        ST_D3    = 4'd5,
        ST_D4    = 4'd6,
        ST_D5    = 4'd7,
        ST_D6    = 4'd8,
        ST_D7    = 4'd9
    } tx_state_e;
endpackage

// File: rtl/sertx_request.sv
module sertx_request
    import sertx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      send,
    input  logic      launch,
    input  tx_state_e state_q,
    output logic      pending,
    output logic      busy
);
    logic active;

    always_comb begin
        active = (state_q != ST_STOP);
        busy   = pending | active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (launch) begin
            pending <= 1'b0;
        end else if (send && !busy) begin
            pending <= 1'b1;
        end
    end

    // R7: a request made while busy leaves the pending flag unchanged
    a_r7_ignore_busy_send: assert property (@(posedge clk) disable iff (!rst_n)
        (send && busy && !launch) |=> (pending == $past(pending)));
endmodule

// File: rtl/sertx_sequencer.sv
module sertx_sequencer
    import sertx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      pending,
    output tx_state_e state_q,
    output tx_state_e state_nx,
    output logic      launch
);
    logic [ST_W-1:0] inc;

    always_comb begin
        inc      = state_q + 1'b1;
        state_nx = state_q;
        unique case (state_q)
            ST_STOP:  state_nx = pending ? ST_START : ST_STOP;
            ST_START: state_nx = ST_D0;
            ST_D7:    state_nx = ST_STOP;
            default:  state_nx = tx_state_e'(inc);
        endcase
        launch = tick && (state_q == ST_STOP) && pending;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else if (tick) begin
            state_q <= state_nx;
        end
    end

    // R5: no state change without a tick
    a_r5_state_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q));

    // R2: idle with nothing pending stays in the stop state
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !pending) |=> (state_q == ST_STOP));
endmodule

// File: rtl/sertx_line_select.sv
module sertx_line_select
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              launch,
    input  logic [DATA_W-1:0] din,
    input  tx_state_e         state_nx,
    output logic              txd
);
    logic [DATA_W-1:0] data_q;
    logic [ST_W-1:0]   off;
    logic              level;

    always_comb begin
        off   = state_nx - ST_D0;
        level = 1'b1;
        unique case (state_nx)
            ST_STOP:  level = 1'b1;
            ST_START: level = 1'b0;
            default: begin
                for (int k = 0; k < DATA_W; k++) begin
                    if (off == ST_W'(k)) level = data_q[k];
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (launch) begin
            data_q <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd <= 1'b1;
        end else if (tick) begin
            txd <= level;
        end
    end

    // R5: the line never moves between ticks
    a_r5_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));
endmodule

// File: rtl/stopfirst_serial_tx.sv
module stopfirst_serial_tx
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              send,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              txd
);
    tx_state_e state_q;
    tx_state_e state_nx;
    logic      launch;
    logic      pending;

    sertx_request u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .send    (send),
        .launch  (launch),
        .state_q (state_q),
        .pending (pending),
        .busy    (busy)
    );

    sertx_sequencer u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .pending  (pending),
        .state_q  (state_q),
        .state_nx (state_nx),
        .launch   (launch)
    );

    sertx_line_select u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bit_tick),
        .launch   (launch),
        .din      (din),
        .state_nx (state_nx),
        .txd      (txd)
    );

    // R3: start state drives low, stop state drives high
    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |-> !txd);
    a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> txd);

    // R8: the last data bit always exits to a stop period on the line
    a_r8_stop_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_D7 && bit_tick) |=> (state_q == ST_STOP && txd));

    // R1: immediately after reset release the block is idle
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (txd && !busy));
endmodule

// File: tb/sim_stopfirst_serial_tx.sv
module sim_stopfirst_serial_tx;
    localparam int T     = 10;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       send = 1'b0;
    logic [7:0] din = 8'h00;
    logic       busy;
    logic       txd;

    int cyc = 0;
    int tcnt = 0;
    int errors = 0;
    int checks = 0;
    int start_cyc = 0;

    stopfirst_serial_tx u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (tick),
        .send     (send),
        .din      (din),
        .busy     (busy),
        .txd      (txd)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (tcnt == T - 1) begin
            tcnt <= 0;
            tick <= 1'b1;
        end else begin
            tcnt <= tcnt + 1;
            tick <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (cyc > LIMIT) begin
            errors++;
            checks++;
            $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_pulse(input logic [7:0] b);
        @(negedge clk);
        din  = b;
        send = 1'b1;
        @(negedge clk);
        send = 1'b0;
        chk("R6 busy after accepted send", int'(busy), 1);
    endtask

    // Waits for a start bit and checks the whole frame at mid-bit points.
    task automatic recv_frame(input logic [7:0] exp, input bit poke);
        int w = 0;
        int pos;
        int expbit;
        while (txd !== 1'b0 && w < 4 * T) begin
            @(negedge clk);
            w++;
        end
        chk("R3 start bit seen", int'(txd === 1'b0), 1);
        if (txd !== 1'b0) return;
        start_cyc = cyc;
        wn(T - 1);
        chk("R5 start bit full length", int'(txd), 0);
        pos = T - 1;
        for (int i = 1; i < 10; i++) begin
            wn(i * T + T / 2 - pos);
            pos = i * T + T / 2;
            expbit = (i == 9) ? 1 : int'(exp[i-1]);
            chk((i == 9) ? "R3 stop bit" : "R3 data bit lsb first", int'(txd), expbit);
            if (i == 5) begin
                chk("R6 busy mid frame", int'(busy), 1);
                if (poke) begin
                    din  = 8'h99;
                    send = 1'b1;
                    @(negedge clk);
                    send = 1'b0;
                    din  = ~exp;
                    pos++;
                end
            end
        end
        chk("R6 busy low after frame", int'(busy), 0);
    endtask

    task automatic t_reset;
        wn(3);
        chk("R1 txd idle in reset", int'(txd), 1);
        chk("R1 busy low in reset", int'(busy), 0);
        rst_n = 1'b1;
        wn(1);
        chk("R1 txd idle after reset", int'(txd), 1);
        chk("R1 busy low after reset", int'(busy), 0);
    endtask

    task automatic t_idle;
        for (int i = 0; i < 5; i++) begin
            wn(T);
            chk("R2 line idle without request", int'(txd), 1);
        end
        chk("R2 busy low when idle", int'(busy), 0);
    endtask

    task automatic t_patterns;
        send_pulse(8'hA5);
        recv_frame(8'hA5, 1'b0);
        send_pulse(8'h00);
        recv_frame(8'h00, 1'b0);
        send_pulse(8'hFF);
        recv_frame(8'hFF, 1'b0);
        send_pulse(8'h01);
        recv_frame(8'h01, 1'b0);
    endtask

    task automatic t_ignore_and_latch;
        // R4 and R7: din changes and an extra send land during the frame
        send_pulse(8'h3C);
        recv_frame(8'h3C, 1'b1);
        for (int i = 0; i < 3; i++) begin
            wn(T);
            chk("R7 no frame from ignored send", int'(txd), 1);
        end
        chk("R7 busy low after ignored send", int'(busy), 0);
    endtask

    task automatic t_phases;
        for (int off = 0; off < 5; off++) begin
            wn(off * 2 + 1);
            send_pulse(8'h6B ^ 8'(off));
            recv_frame(8'h6B ^ 8'(off), 1'b0);
        end
    endtask

    task automatic t_back_to_back;
        int first;
        send_pulse(8'hC3);
        recv_frame(8'hC3, 1'b0);
        first = start_cyc;
        send_pulse(8'h5A);
        recv_frame(8'h5A, 1'b0);
        chk("R8 frame spacing at least ten bit periods",
            int'((start_cyc - first) >= 10 * T), 1);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_patterns();
        t_ignore_and_latch();
        t_phases();
        t_back_to_back();
        wn(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule